// File: doc/BRIEF.md
# Serial Clock Mode Detector

This block sits between the serial audio input pins and a DAC datapath and runs entirely in the master clock domain. It decides, on its own, whether a bit clock is being supplied from outside. If at least 16 bit-clock rising edges land inside one half of a frame clock period, the block switches to external mode. It falls back to internal mode once two whole frame periods pass with no bit-clock activity.

In internal mode the block generates its own bit clock from the master clock and restarts it on every frame clock transition. The bit clock runs at 32, 48 or 64 times the frame rate, picked by two format bits. In this mode the bit-clock pin is free to act as the upper de-emphasis select bit, so all three de-emphasis rates can be chosen. In external mode that pin is busy, so only "off" and 44.1 kHz remain. A high-rate flag forces de-emphasis off. The filter arithmetic is outside this block.

Top module: `sclk_mode_detect`

## Requirements
- R1: The frame clock and bit-clock pin each pass through a two-flop synchronizer. `ext_mode_o` rises on the clock edge that consumes the 16th synchronized bit-clock rising edge counted since the last synchronized frame clock transition.
- R2: The rising-edge count restarts at every synchronized frame clock transition, whether rising or falling. 15 bit-clock rises per frame half, repeated indefinitely, never set `ext_mode_o`.
- R3: Once in external mode, `ext_mode_o` falls on the third synchronized frame clock rising edge seen with no synchronized bit-clock rise since the last one, which is two complete frame periods. It stays high before that point.
- R4: While `rst_ni` is low, and after release until inputs act, `ext_mode_o`=0, `bclk_o`=0 and `deemph_o`=2'b00.
- R5: In internal mode `bclk_o` is forced low on the cycle after a synchronized frame clock transition. It then toggles every FRAME_MCLKS/(2*ratio) master clocks. `fmt_i` 2'b00 gives ratio 32, 2'b01 gives 48, and 2'b10 or 2'b11 give 64, so each frame carries exactly `ratio` rising edges.
- R6: In external mode `bclk_o` equals the synchronized bit-clock pin, which is the pin delayed by two master clocks.
- R7: In internal mode, with `hrm_i`=0, `deemph_o` takes {synchronized pin, `dem0_i`} one clock later. The encoding is 00 off, 01 44.1 kHz, 10 48 kHz and 11 32 kHz.
- R8: In external mode, with `hrm_i`=0, `deemph_o` takes {0, `dem0_i`}, so bit 1 is always 0.
- R9: When `hrm_i`=1, `deemph_o` is 2'b00 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lrck_i | input | 1 | Frame clock (asynchronous) |
| sclk_pin_i | input | 1 | Bit-clock pin; upper de-emphasis select bit when internal |
| fmt_i | input | 2 | Format select, sets internal bit clock ratio |
| dem0_i | input | 1 | Lower de-emphasis select bit |
| hrm_i | input | 1 | High-rate mode, disables de-emphasis |
| ext_mode_o | output | 1 | 1 when the bit clock is supplied externally |
| bclk_o | output | 1 | Effective bit clock |
| deemph_o | output | 2 | Selected de-emphasis rate |

## Verification
A wrong edge count or idle count shows up directly on `ext_mode_o`. The flag switches one cycle early or late, or not at all within a frame half, and `bclk_o` changes source on that same edge. A divider that drifts from the frame-relative phase shows a misplaced `bclk_o` transition within a few master clocks of the next frame clock transition. A stale mode flag inside the de-emphasis logic shows as a wrong bit 1 on `deemph_o` one clock after the mode changes. The bench compares all three outputs with its reference model on every clock, so any of these faults is reported on the cycle where it first appears.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [1:0] {
    DEM_OFF  = 2'b00,
    DEM_44K1 = 2'b01,
    DEM_48K  = 2'b10,
    DEM_32K  = 2'b11
  } dem_rate_e;

  typedef enum logic [1:0] {
    FMT_R32  = 2'b00,
    FMT_R48  = 2'b01,
    FMT_R64  = 2'b10,
    FMT_R64B = 2'b11
  } fmt_e;
endpackage

// File: rtl/scm_sync.sv
module scm_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/scm_mode_det.sv
module scm_mode_det #(
  parameter int EDGE_THRESH = 16,
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_s_i,
  input  logic sclk_s_i,
  output logic lrck_tgl_o,
  output logic ext_o
);
  localparam int RCW        = $clog2(EDGE_THRESH + 1);
  localparam int IDLE_LIMIT = IDLE_FRAMES + 1;
  localparam int ICW        = $clog2(IDLE_LIMIT + 1);

  logic           lrck_d, sclk_d, ext_q;
  logic           lrck_rise, sclk_rise, enter, leave;
  logic [RCW-1:0] rise_cnt;
  logic [ICW-1:0] idle_cnt;

  assign lrck_tgl_o = lrck_s_i ^ lrck_d;
  assign lrck_rise  = lrck_s_i & ~lrck_d;
  assign sclk_rise  = sclk_s_i & ~sclk_d;

  assign enter = sclk_rise && !lrck_tgl_o && (rise_cnt == RCW'(EDGE_THRESH - 1));
  assign leave = ext_q && !sclk_rise && lrck_rise && (idle_cnt == ICW'(IDLE_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_d   <= 1'b0;
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      idle_cnt <= '0;
      ext_q    <= 1'b0;
    end else begin
      lrck_d <= lrck_s_i;
      sclk_d <= sclk_s_i;
      // count restarts per frame half; a rise coinciding with the boundary is the first of the new half
      if (lrck_tgl_o)
        rise_cnt <= sclk_rise ? RCW'(1) : '0;
      else if (sclk_rise && rise_cnt != RCW'(EDGE_THRESH))
        rise_cnt <= rise_cnt + RCW'(1);
      if (sclk_rise)
        idle_cnt <= '0;
      else if (lrck_rise && idle_cnt != ICW'(IDLE_LIMIT))
        idle_cnt <= idle_cnt + ICW'(1);
      if (enter)      ext_q <= 1'b1;
      else if (leave) ext_q <= 1'b0;
    end
  end

  assign ext_o = ext_q;

  AST_ENTER_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_q) |-> $past(sclk_rise)); // R1
  AST_LEAVE_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_q) |-> ($past(lrck_rise) && !$past(sclk_rise))); // R3
  AST_RISE_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt <= RCW'(EDGE_THRESH)); // R2
  AST_TGL_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_tgl_o && !sclk_rise) |=> (rise_cnt == '0)); // R2
endmodule

// File: rtl/scm_bclk_gen.sv
module scm_bclk_gen #(
  parameter int FRAME_MCLKS = 384
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lrck_tgl_i,
  input  logic [1:0] fmt_i,
  output logic       bclk_o
);
  import scm_pkg::*;
  localparam int HALF_R32 = FRAME_MCLKS / 64;
  localparam int HALF_R48 = FRAME_MCLKS / 96;
  localparam int HALF_R64 = FRAME_MCLKS / 128;
  localparam int DW       = $clog2(HALF_R32 + 1);

  logic [DW-1:0] div_cnt, half_m1;
  logic          bclk_q;

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_R32: half_m1 = DW'(HALF_R32 - 1);
      FMT_R48: half_m1 = DW'(HALF_R48 - 1);
      default: half_m1 = DW'(HALF_R64 - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (lrck_tgl_i) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (div_cnt >= half_m1) begin
      // >= keeps a mid-phase ratio change from running past the terminal count
      div_cnt <= '0;
      bclk_q  <= ~bclk_q;
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end

  assign bclk_o = bclk_q;

  AST_BCLK_LOW_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrck_tgl_i |=> !bclk_q); // R5
  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt < DW'(HALF_R32)); // R5
endmodule

// File: rtl/scm_deemph.sv
module scm_deemph (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_i,
  input  logic       pin_i,
  input  logic       dem0_i,
  input  logic       hrm_i,
  output logic [1:0] rate_o
);
  import scm_pkg::*;
  dem_rate_e rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rate_q <= DEM_OFF;
    else if (hrm_i)  rate_q <= DEM_OFF;
    else if (ext_i)  rate_q <= dem0_i ? DEM_44K1 : DEM_OFF;
    else             rate_q <= dem_rate_e'({pin_i, dem0_i});
  end

  assign rate_o = rate_q;

  AST_HRM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrm_i |=> (rate_o == 2'b00)); // R9
  AST_EXT_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_i |=> !rate_o[1]); // R8
endmodule

// File: rtl/sclk_mode_detect.sv
module sclk_mode_detect #(
  parameter int FRAME_MCLKS = 384,
  parameter int EDGE_THRESH = 16,
  parameter int IDLE_FRAMES = 2
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic       lrck_i,
  input  logic       sclk_pin_i,
  input  logic [1:0] fmt_i,
  input  logic       dem0_i,
  input  logic       hrm_i,
  output logic       ext_mode_o,
  output logic       bclk_o,
  output logic [1:0] deemph_o
);
  logic lrck_s, sclk_s, lrck_tgl, ext, bclk_int;

  scm_sync #(.W(2)) u_sync (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .d_i   ({lrck_i, sclk_pin_i}),
    .q_o   ({lrck_s, sclk_s})
  );

  scm_mode_det #(.EDGE_THRESH(EDGE_THRESH), .IDLE_FRAMES(IDLE_FRAMES)) u_mode (
    .clk_i     (mclk_i),
    .rst_ni    (rst_ni),
    .lrck_s_i  (lrck_s),
    .sclk_s_i  (sclk_s),
    .lrck_tgl_o(lrck_tgl),
    .ext_o     (ext)
  );

  scm_bclk_gen #(.FRAME_MCLKS(FRAME_MCLKS)) u_bclk (
    .clk_i     (mclk_i),
    .rst_ni    (rst_ni),
    .lrck_tgl_i(lrck_tgl),
    .fmt_i     (fmt_i),
    .bclk_o    (bclk_int)
  );

  scm_deemph u_dem (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .ext_i (ext),
    .pin_i (sclk_s),
    .dem0_i(dem0_i),
    .hrm_i (hrm_i),
    .rate_o(deemph_o)
  );

  assign ext_mode_o = ext;
  assign bclk_o     = ext ? sclk_s : bclk_int;

  AST_RESET_INTERNAL: assert property (@(posedge mclk_i)
    !rst_ni |-> !ext_mode_o); // R4
endmodule

// File: tb/sclk_mode_detect_tb_top.sv
`timescale 1ns/1ps
module sclk_mode_detect_tb_top;
  localparam int FRAME = 384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0, pin = 1'b0, dem0 = 1'b0, hrm = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic ext_o, bclk_o;
  logic [1:0] dem_o;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sclk_mode_detect dut_i (
    .mclk_i(clk), .rst_ni(rst_n), .lrck_i(lrck), .sclk_pin_i(pin),
    .fmt_i(fmt), .dem0_i(dem0), .hrm_i(hrm),
    .ext_mode_o(ext_o), .bclk_o(bclk_o), .deemph_o(dem_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // stimulus: 0 static pin level, 1 free-running bit clock, 2 fifteen rises per frame half
  int  sc_mode = 0;
  bit  dem1_lvl = 1'b0;
  int  lr_cnt = 0, sc_cnt = 0, burst = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lr_cnt == FRAME/2 - 1) begin
        lr_cnt = 0;
        lrck <= ~lrck;
        if (sc_mode == 2) burst = 15;
      end else lr_cnt++;
      if (sc_mode == 0) begin
        pin <= dem1_lvl;
        sc_cnt = 0;
      end else if (sc_cnt == 2) begin
        sc_cnt = 0;
        if (sc_mode == 1 || burst > 0) begin
          if (!pin && burst > 0) burst--;
          pin <= ~pin;
        end
      end else sc_cnt++;
    end
  end

  // reference model
  bit m_l1, m_l2, m_l3, m_s1, m_s2, m_s3, m_ext, m_bint, dirty;
  int m_rise, m_idle, m_pos;
  logic [1:0] m_dem, fmt_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_l1, m_l2, m_l3, m_s1, m_s2, m_s3, m_ext, m_bint, dirty} = '0;
      m_rise = 0; m_idle = 0; m_pos = 0; m_dem = 2'b00; fmt_prev = fmt;
    end else begin
      automatic bit tgl   = m_l2 ^ m_l3;
      automatic bit lrise = m_l2 & !m_l3;
      automatic bit srise = m_s2 & !m_s3;
      automatic bit nx    = m_ext;
      automatic int half  = (fmt == 2'b00) ? FRAME/64 : (fmt == 2'b01) ? FRAME/96 : FRAME/128;
      if (hrm)        m_dem = 2'b00;
      else if (m_ext) m_dem = {1'b0, dem0};
      else            m_dem = {m_s2, dem0};
      if (srise && !tgl && m_rise == 15) nx = 1'b1;
      else if (m_ext && !srise && lrise && m_idle == 2) nx = 1'b0;
      m_ext = nx;
      if (tgl) m_rise = srise ? 1 : 0;
      else if (srise && m_rise < 16) m_rise++;
      if (srise) m_idle = 0;
      else if (lrise && m_idle < 3) m_idle++;
      if (tgl) begin m_pos = 0; dirty = 1'b0; end
      else begin m_pos++; if (fmt != fmt_prev) dirty = 1'b1; end
      fmt_prev = fmt;
      m_bint = ((m_pos / half) % 2) == 1;
      m_l3 = m_l2; m_l2 = m_l1; m_l1 = lrck;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  // per-cycle comparison
  int bclk_rises = 0;
  logic bclk_prev = 1'b0;
  always @(negedge clk) begin
    chk(ext_o == m_ext, "R1|R3 ext_mode", ext_o, m_ext);
    chk(dem_o == m_dem, "R7|R8|R9 deemph", dem_o, m_dem);
    if (m_ext) chk(bclk_o == m_s2, "R6 bclk ext", bclk_o, m_s2);
    else if (!dirty) chk(bclk_o == m_bint, "R5 bclk int", bclk_o, m_bint);
    if (bclk_o && !bclk_prev) bclk_rises++;
    bclk_prev = bclk_o;
  end

  task automatic frames(input int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  task automatic count_rises(input int exp, input string req);
    bclk_rises = 0;
    frames(1);
    chk(bclk_rises == exp, req, bclk_rises, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(ext_o == 1'b0 && bclk_o == 1'b0 && dem_o == 2'b00, "R4 reset", {ext_o, bclk_o, dem_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ext_o == 1'b0 && dem_o == 2'b00, "R4 after release", {ext_o, dem_o}, 0);
    dem1_lvl = 1'b1;
    frames(2);
    chk(dem_o == 2'b10, "R7 48k", dem_o, 2);
    chk(ext_o == 1'b0, "R5 stays internal", ext_o, 0);
    count_rises(32, "R5 ratio 32");
    fmt = 2'b01; frames(1); count_rises(48, "R5 ratio 48");
    fmt = 2'b10; frames(1); count_rises(64, "R5 ratio 64");
    fmt = 2'b11; frames(1); count_rises(64, "R5 ratio 64 alt code");
    dem0 = 1'b1; frames(1);
    chk(dem_o == 2'b11, "R7 32k", dem_o, 3);
    hrm = 1'b1; repeat (3) @(negedge clk);
    chk(dem_o == 2'b00, "R9 high rate off", dem_o, 0);
    hrm = 1'b0; dem1_lvl = 1'b0; repeat (6) @(negedge clk);
    chk(dem_o == 2'b01, "R7 44k1", dem_o, 1);
    sc_mode = 2; frames(3);
    chk(ext_o == 1'b0, "R2 fifteen rises per half", ext_o, 0);
    sc_mode = 1; frames(1);
    chk(ext_o == 1'b1, "R1 enter external", ext_o, 1);
    chk(dem_o == 2'b01, "R8 external 44k1", dem_o, 1);
    count_rises(64, "R6 external follows pin");
    dem0 = 1'b0; repeat (4) @(negedge clk);
    chk(dem_o == 2'b00, "R8 external off", dem_o, 0);
    sc_mode = 0; dem1_lvl = 1'b0; frames(1);
    chk(ext_o == 1'b1, "R3 not yet timed out", ext_o, 1);
    frames(3);
    chk(ext_o == 1'b0, "R3 timeout to internal", ext_o, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule